// File: doc/BRIEF.md
# Beam Pattern Pipeline Sequencer

This block sits inside an event generator and runs once per beam fiducial, at 360 Hz, which is six pulses per 60 Hz power-line period. It holds a three-deep pipeline of future beam patterns. Each pattern is a 5-bit beam code plus 192 modifier bits. A pattern generator loads a new pattern some time before each fiducial. On the fiducial the pipeline shifts, the loaded pattern enters at the far end, and the block presents the frame for the pulse now being fired. The frame carries a pulse identifier, a power-line timeslot index and the current pattern.

The block also keeps a table of up to 16 event rules. Each rule has an enable, a modifier-bit mask, a match value and an 8-bit event code. The rules are not tested against the current pattern. They are tested against the pattern one pulse ahead, so the event codes for the coming pulse can be broadcast early. If no pattern arrives before a fiducial, an all-zero pattern takes its place and a sticky underrun flag is raised. A sync input realigns the timeslot count to the start of the power-line period.

Top module: `timing_pattern_seq`

## Requirements
- R1: `frm_valid` is high for exactly the one clock cycle that follows a clock edge on which `fid` is high. All frame and event outputs change only on such edges.
- R2: `frm_pid` is 0 after reset and steps by one on every fiducial. It wraps to 0 after its maximum value of 2^PID_W-1, where PID_W is 17 by default.
- R3: `frm_slot` is 6 after reset. On every fiducial without sync it advances 1,2,3,4,5,6,1,…, so the first frame after reset carries slot 1.
- R4: A `sync_in` pulse forces `frm_slot` to 1 on the next fiducial. This holds whether the pulse arrives in any cycle since the previous fiducial or in the fiducial cycle itself.
- R5: Consider a pattern loaded with `ld_valid` in any cycle after fiducial k-1, up to and including the cycle of fiducial k. It is the current pattern (`frm_code`, `frm_mod`) in the frame of fiducial k+2.
- R6: When several patterns are loaded between two fiducials, only the most recent one enters the pipeline.
- R7: A fiducial with no pattern loaded since the previous fiducial inserts an all-zero pattern and sets `underrun`. `underrun` then stays set until reset.
- R8: In the frame of fiducial k, `evt_fire[i]` is 1 exactly when rule i is enabled and (pattern AND mask) equals match. The pattern tested is the one that becomes current at fiducial k+1. Slice i of `evt_list` (bits 8i+7:8i) holds the rule's code when `evt_fire[i]` is 1, and 0 otherwise.
- R9: A cycle with `rule_we` high writes the enable, mask, match and code to entry `rule_idx`. The new entry is used from the next fiducial onward.
- R10: While reset is held, and after it until the first fiducial, the following are all 0: `frm_valid`, `frm_pid`, `frm_code`, `frm_mod`, `evt_fire`, `evt_list` and `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fid | input | 1 | One-cycle beam fiducial strobe |
| sync_in | input | 1 | Timeslot realignment request |
| ld_valid | input | 1 | Pattern load strobe |
| ld_code | input | 5 | Beam code of the loaded pattern |
| ld_mod | input | 192 | Modifier bits of the loaded pattern |
| rule_we | input | 1 | Event rule write strobe |
| rule_idx | input | 4 | Event rule entry index |
| rule_en | input | 1 | Enable written to the entry |
| rule_mask | input | 192 | Modifier-bit mask written to the entry |
| rule_match | input | 192 | Match value written to the entry |
| rule_code | input | 8 | Event code written to the entry |
| frm_valid | output | 1 | Frame strobe, one cycle after each fiducial |
| frm_pid | output | 17 | Pulse identifier of the frame |
| frm_slot | output | 3 | Power-line timeslot, 1 to 6 |
| frm_code | output | 5 | Beam code of the current pulse |
| frm_mod | output | 192 | Modifier bits of the current pulse |
| evt_fire | output | 16 | Per-rule hit flags for the next pulse |
| evt_list | output | 128 | Per-rule event codes, 0 where a rule did not hit |
| underrun | output | 1 | Sticky missing-pattern flag |

## Verification
Every result is registered on the fiducial edge. This means the frame, the event flags and `underrun` are due in the first cycle after that edge, and the bench samples them at the falling edge of that cycle. A loaded pattern is due in the frame two fiducials after the one that takes it in. The events it produces are due one fiducial earlier. The bench tracks both offsets with a three-entry model pipeline instead of counting cycles. A sync pulse or a rule write must show in the frame of the next fiducial. Every cycle without a fiducial is also checked for a low `frm_valid`.

// File: rtl/timing_pattern_seq.sv
module timing_pattern_seq #(
  parameter int CODE_W = 5,
  parameter int MOD_W  = 192,
  parameter int PID_W  = 17,
  parameter int NRULE  = 16,
  parameter int EVC_W  = 8,
  localparam int IDX_W = (NRULE > 1) ? $clog2(NRULE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fid,
  input  logic                   sync_in,
  input  logic                   ld_valid,
  input  logic [CODE_W-1:0]      ld_code,
  input  logic [MOD_W-1:0]       ld_mod,
  input  logic                   rule_we,
  input  logic [IDX_W-1:0]       rule_idx,
  input  logic                   rule_en,
  input  logic [MOD_W-1:0]       rule_mask,
  input  logic [MOD_W-1:0]       rule_match,
  input  logic [EVC_W-1:0]       rule_code,
  output logic                   frm_valid,
  output logic [PID_W-1:0]       frm_pid,
  output logic [2:0]             frm_slot,
  output logic [CODE_W-1:0]      frm_code,
  output logic [MOD_W-1:0]       frm_mod,
  output logic [NRULE-1:0]       evt_fire,
  output logic [NRULE*EVC_W-1:0] evt_list,
  output logic                   underrun
);

  logic [CODE_W-1:0] c0, c1, c2, pend_code, in_code;
  logic [MOD_W-1:0]  m0, m1, m2, pend_mod, in_mod;
  logic              pend_v, sync_pend, have_pat, sync_now;
  logic [NRULE-1:0]  hit;
  logic [NRULE*EVC_W-1:0] list_d;

  assign have_pat = ld_valid | pend_v;
  assign in_code  = ld_valid ? ld_code : (pend_v ? pend_code : '0);
  assign in_mod   = ld_valid ? ld_mod  : (pend_v ? pend_mod  : '0);
  assign sync_now = sync_in | sync_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_code <= '0;
      pend_mod  <= '0;
      sync_pend <= 1'b0;
    end else if (fid) begin
      pend_v    <= 1'b0;
      sync_pend <= 1'b0;
    end else begin
      if (ld_valid) begin
        pend_v    <= 1'b1;
        pend_code <= ld_code;
        pend_mod  <= ld_mod;
      end
      if (sync_in) sync_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0 <= '0; c1 <= '0; c2 <= '0;
      m0 <= '0; m1 <= '0; m2 <= '0;
      frm_pid  <= '0;
      frm_slot <= 3'd6;
      underrun <= 1'b0;
      evt_fire <= '0;
      evt_list <= '0;
    end else if (fid) begin
      c0 <= c1; c1 <= c2; c2 <= in_code;
      m0 <= m1; m1 <= m2; m2 <= in_mod;
      frm_pid  <= frm_pid + 1'b1;
      frm_slot <= (sync_now || frm_slot == 3'd6) ? 3'd1 : frm_slot + 3'd1;
      if (!have_pat) underrun <= 1'b1;
      evt_fire <= hit;
      evt_list <= list_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frm_valid <= 1'b0;
    else        frm_valid <= fid;
  end

  assign frm_code = c0;
  assign frm_mod  = m0;

  for (genvar i = 0; i < NRULE; i++) begin : g_rule
    logic             en_q;
    logic [MOD_W-1:0] mask_q, match_q;
    logic [EVC_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q    <= 1'b0;
        mask_q  <= '0;
        match_q <= '0;
        code_q  <= '0;
      end else if (rule_we && rule_idx == IDX_W'(i)) begin
        en_q    <= rule_en;
        mask_q  <= rule_mask;
        match_q <= rule_match;
        code_q  <= rule_code;
      end
    end

    assign hit[i] = en_q && ((m2 & mask_q) == match_q);
    assign list_d[i*EVC_W +: EVC_W] = hit[i] ? code_q : '0;
  end

endmodule

module timing_pattern_seq_chk #(
  parameter int PID_W = 17,
  parameter int NRULE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fid,
  input logic             frm_valid,
  input logic [PID_W-1:0] frm_pid,
  input logic [2:0]       frm_slot,
  input logic [NRULE-1:0] evt_fire,
  input logic             underrun
);

  // R1
  strobe_after_fid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fid |=> frm_valid);

  // R1
  strobe_only_fid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fid |=> !frm_valid);

  // R1
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fid |=> ($stable(frm_pid) && $stable(frm_slot) && $stable(evt_fire)));

  // R2
  pid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fid |=> frm_pid == PID_W'($past(frm_pid) + 1'b1));

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_slot >= 3'd1 && frm_slot <= 3'd6);

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

endmodule

bind timing_pattern_seq timing_pattern_seq_chk #(.PID_W(PID_W), .NRULE(NRULE)) u_chk (
  .clk(clk), .rst_n(rst_n), .fid(fid), .frm_valid(frm_valid),
  .frm_pid(frm_pid), .frm_slot(frm_slot), .evt_fire(evt_fire), .underrun(underrun));

// File: tb/timing_pattern_seq_tb.sv
module timing_pattern_seq_tb;
  localparam int PID_W = 6;
  localparam int NRULE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fid = 0, sync_in = 0, ld_valid = 0, rule_we = 0, rule_en = 0;
  logic [4:0]   ld_code = '0;
  logic [191:0] ld_mod = '0, rule_mask = '0, rule_match = '0;
  logic [3:0]   rule_idx = '0;
  logic [7:0]   rule_code = '0;
  logic         frm_valid, underrun;
  logic [PID_W-1:0] frm_pid;
  logic [2:0]   frm_slot;
  logic [4:0]   frm_code;
  logic [191:0] frm_mod;
  logic [NRULE-1:0] evt_fire;
  logic [NRULE*8-1:0] evt_list;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  timing_pattern_seq #(.PID_W(PID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fid(fid), .sync_in(sync_in), .ld_valid(ld_valid),
    .ld_code(ld_code), .ld_mod(ld_mod), .rule_we(rule_we), .rule_idx(rule_idx),
    .rule_en(rule_en), .rule_mask(rule_mask), .rule_match(rule_match),
    .rule_code(rule_code), .frm_valid(frm_valid), .frm_pid(frm_pid),
    .frm_slot(frm_slot), .frm_code(frm_code), .frm_mod(frm_mod),
    .evt_fire(evt_fire), .evt_list(evt_list), .underrun(underrun));

  logic [4:0]   e_c [3];
  logic [191:0] e_m [3];
  logic [PID_W-1:0] e_pid;
  logic [2:0]   e_slot;
  logic         e_under, p_v, s_m;
  logic [4:0]   p_c;
  logic [191:0] p_m;
  logic [NRULE-1:0] e_fire;
  logic [NRULE*8-1:0] e_list;
  logic         t_en [NRULE];
  logic [191:0] t_mask [NRULE];
  logic [191:0] t_match [NRULE];
  logic [7:0]   t_code [NRULE];

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [191:0] rnd_mod();
    logic [191:0] r;
    for (int k = 0; k < 6; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [2:0] next_slot(input logic [2:0] s, input logic sy);
    return (sy || s == 3'd6) ? 3'd1 : s + 3'd1;
  endfunction

  task automatic wr_rule(input int i, input logic en, input logic [191:0] mk, input logic [191:0] mt, input logic [7:0] cd);
    @(negedge clk);
    rule_we = 1; rule_idx = 4'(i); rule_en = en; rule_mask = mk; rule_match = mt; rule_code = cd;
    @(negedge clk);
    rule_we = 0;
    t_en[i] = en; t_mask[i] = mk; t_match[i] = mt; t_code[i] = cd;
  endtask

  task automatic check_frame(input string tag);
    chk("R1", {tag, " frm_valid"}, 256'(frm_valid), 256'(1));
    chk("R2", {tag, " pid"}, 256'(frm_pid), 256'(e_pid));
    chk("R3_R4", {tag, " slot"}, 256'(frm_slot), 256'(e_slot));
    chk("R5_R6", {tag, " code"}, 256'(frm_code), 256'(e_c[0]));
    chk("R5_R6", {tag, " mod"}, 256'(frm_mod), 256'(e_m[0]));
    chk("R8_R9", {tag, " evt_fire"}, 256'(evt_fire), 256'(e_fire));
    chk("R8", {tag, " evt_list"}, 256'(evt_list), 256'(e_list));
    chk("R7", {tag, " underrun"}, 256'(underrun), 256'(e_under));
  endtask

  task automatic step(input logic f, input logic l, input logic s, input string tag);
    logic [4:0] c; logic [191:0] m;
    c = 5'($urandom); m = rnd_mod();
    m[7:0] = 8'($urandom);
    @(negedge clk);
    fid = f; ld_valid = l; sync_in = s; ld_code = c; ld_mod = m;
    @(negedge clk);
    fid = 0; ld_valid = 0; sync_in = 0;
    if (f) begin
      for (int i = 0; i < NRULE; i++) begin
        e_fire[i] = t_en[i] && ((e_m[2] & t_mask[i]) == t_match[i]);
        e_list[i*8 +: 8] = e_fire[i] ? t_code[i] : 8'd0;
      end
      if (!(l || p_v)) e_under = 1;
      e_c[0] = e_c[1]; e_c[1] = e_c[2];
      e_m[0] = e_m[1]; e_m[1] = e_m[2];
      e_c[2] = l ? c : (p_v ? p_c : 5'd0);
      e_m[2] = l ? m : (p_v ? p_m : 192'd0);
      e_pid = e_pid + 1'b1;
      e_slot = next_slot(e_slot, s || s_m);
      p_v = 0; s_m = 0;
      check_frame(tag);
    end else begin
      if (l) begin p_v = 1; p_c = c; p_m = m; end
      if (s) s_m = 1;
      chk("R1", {tag, " idle frm_valid"}, 256'(frm_valid), 256'(0));
      chk("R1", {tag, " idle pid"}, 256'(frm_pid), 256'(e_pid));
    end
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    for (int k = 0; k < 3; k++) begin e_c[k] = '0; e_m[k] = '0; end
    e_pid = '0; e_slot = 3'd6; e_under = 0; p_v = 0; s_m = 0; p_c = '0; p_m = '0;
    e_fire = '0; e_list = '0;
    for (int i = 0; i < NRULE; i++) begin t_en[i] = 0; t_mask[i] = '0; t_match[i] = '0; t_code[i] = '0; end

    repeat (3) @(negedge clk);
    // R10 reset state while held and after release
    chk("R10", "reset valid", 256'(frm_valid), 256'(0));
    chk("R10", "reset underrun", 256'(underrun), 256'(0));
    rst_n = 1;
    @(negedge clk);
    chk("R10", "idle pid", 256'(frm_pid), 256'(0));
    chk("R10", "idle code/mod", 256'({frm_code, frm_mod}), 256'(0));
    chk("R10", "idle evt", 256'({evt_fire, evt_list}), 256'(0));
    chk("R3", "reset slot", 256'(frm_slot), 256'(6));

    for (int i = 0; i < NRULE; i++) begin
      logic [191:0] mk, mt;
      mk = '0;
      for (int b = 0; b < 3; b++) mk[$urandom % 8] = 1'b1;
      mt = 192'($urandom) & mk;
      if (i == 15) begin mk = '0; mt = '0; end
      wr_rule(i, (i != 3), mk, mt, 8'(i * 16 + 1));
    end

    // R7 first fiducial with nothing loaded
    step(1, 0, 0, "R7 empty");
    // R6 two loads then a fiducial
    step(0, 1, 0, "R6 load a");
    step(0, 1, 0, "R6 load b");
    step(1, 0, 0, "R6 fid");
    // R5 load in the fiducial cycle itself
    step(1, 1, 0, "R5 same-cycle");
    step(1, 1, 0, "R5 next");
    step(1, 1, 0, "R5 third");
    // R4 sync in idle cycle and in the fiducial cycle
    step(0, 1, 1, "R4 sync idle");
    step(1, 0, 0, "R4 fid");
    step(1, 1, 1, "R4 sync at fid");
    // R9 rewrite rule 15 to never fire
    wr_rule(15, 1, 192'h1, 192'h2, 8'hEE);
    step(1, 1, 0, "R9 after write");
    step(1, 1, 0, "R9 later");

    for (int n = 0; n < 3000; n++) begin
      logic f, l, s;
      f = ($urandom % 3) == 0;
      l = ($urandom % 5) != 0;
      s = ($urandom % 25) == 0;
      if (n == 1500) wr_rule(5, 1, 192'h3, 192'h1, 8'hA5);
      step(f, l, s, "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule